// File: doc/BRIEF.md
# Parallel RGB Panel Sync and Timing Generator

This block produces the line sync, frame sync, data-enable and pixel-request strobes for a parallel RGB display that is clocked by a pixel (dot) clock. Software programs the line and frame geometry as plain counts: the total line length, the sync widths, the wait counts and the active sizes. The block then walks a pixel counter and a line counter across every frame and decodes the strobes from them. Polarity inputs choose the active level of each strobe, and a further output tells the pad logic which dot-clock edge launches data.

Two pieces of control sit around the counters. A buffer-swap stage holds a pending frame address and moves it into the current-frame address only at the first pixel of a frame, so a new address never takes effect partway down the screen. A run controller starts the counters as soon as display mode is requested. It keeps them running after the request is withdrawn until the upstream pixel supply reports empty. Every sync output sits at its inactive level while the block is idle.

Top module: `rgb_panel_timer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `run_status` is 0, `cur_buf` is 0, `pix_req` is 0, and `hsync`, `vsync` and `de` each sit at the inactive level of their polarity input.
- R2: A line lasts `cfg_h_total` clocks, and the line sync is active during the first `cfg_hs_width` clocks of each line (pixel index 0 counts as the first clock).
- R3: A frame lasts `cfg_v_total` lines, and the frame sync is active during the first `cfg_vs_width` whole lines of each frame.
- R4: `de` is active exactly when the pixel index is in [`cfg_h_wait`, `cfg_h_wait`+`cfg_h_valid`) and the line index is in [`cfg_v_wait`, `cfg_v_wait`+`cfg_v_active`). Both wait counts are measured from the start of the sync pulse. `de`, `hsync` and `vsync` describe the same pixel in the same cycle.
- R5: `pix_req` is active-high and is asserted exactly one clock before each cycle in which `de` is active.
- R6: A polarity input of 1 makes its strobe active-high, and 0 makes it active-low. The inactive level is always the complement of the active level.
- R7: While `sync_en` is 0, `hsync` and `vsync` hold their inactive level (one clock later), and `de` and `pix_req` keep their normal timing.
- R8: `frame_start` pulses for one clock each time a frame begins. In that same cycle `cur_buf` takes the value last written through `next_buf_wr`/`next_buf_addr`, and `cur_buf` changes at no other time.
- R9: `run_status` rises the clock after `mode_en` is seen high while idle. The first frame then begins at pixel 0 of line 0, and `frame_start` follows one clock later.
- R10: Once running, `run_status` stays 1 while `mode_en` is 0 and `fifo_empty` is 0. It clears the clock after both are seen (`mode_en` 0 and `fifo_empty` 1), and two clocks later all strobes are inactive and `pix_req` is 0.
- R11: `dclk_fall` follows `cfg_clk_fall` one clock later: 1 selects the falling dot-clock edge to launch data, 0 the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_h_total | input | H_W | Clocks per line |
| cfg_hs_width | input | HS_W | Line sync width in clocks |
| cfg_h_wait | input | H_W | Clocks from line start to first active pixel |
| cfg_h_valid | input | H_W | Active pixels per line |
| cfg_v_total | input | V_W | Lines per frame |
| cfg_vs_width | input | VS_W | Frame sync width in lines |
| cfg_v_wait | input | V_W | Lines from frame start to first active line |
| cfg_v_active | input | V_W | Active lines per frame |
| cfg_hs_pol | input | 1 | 1: line sync active-high |
| cfg_vs_pol | input | 1 | 1: frame sync active-high |
| cfg_de_pol | input | 1 | 1: data enable active-high |
| cfg_clk_fall | input | 1 | 1: launch data on falling dot-clock edge |
| mode_en | input | 1 | Display mode request |
| sync_en | input | 1 | Drive sync outputs |
| fifo_empty | input | 1 | Upstream pixel supply is empty |
| next_buf_wr | input | 1 | Write strobe for pending frame address |
| next_buf_addr | input | A_W | Pending frame address |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| pix_req | output | 1 | Pixel request, one clock ahead of data enable |
| dclk_fall | output | 1 | Dot-clock launch edge select |
| run_status | output | 1 | Counters running |
| frame_start | output | 1 | One-clock pulse at each frame start |
| cur_buf | output | A_W | Address of the frame being shown |

## Verification
The hardest case to reach is the drained stop. `mode_en` has already dropped, yet the counters must keep producing strobes until `fifo_empty` arrives, and the outputs must then settle two clocks later. The bench holds the supply non-empty for several clocks after the request is withdrawn, then raises `fifo_empty` and checks the `run_status` edge and the settled strobes. A second case is a frame address written mid-frame. The bench writes it partway through a frame and checks that `cur_buf` keeps the old value until the next `frame_start`. Whole frames are compared clock by clock against a position model, under both polarity sets and with `sync_en` low.

// File: rtl/rgb_timer_pkg.sv
package rgb_timer_pkg;
  // Raw strobe decode for one pixel position, before polarity.
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } strobe_t;
endpackage

// File: rtl/rgb_span_counter.sv
// Wrapping up-counter: counts 0 .. limit-1 while step is high.
module rgb_span_counter #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W:0] nxt;

  assign nxt  = {1'b0, cnt} + 1'b1;
  // A limit of 0 or 1 wraps every step.
  assign wrap = step && (nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (step)
      cnt <= wrap ? '0 : nxt[W-1:0];
  end
endmodule

// File: rtl/rgb_window_decode.sv
// Decodes sync and enable windows from the pixel and line indices.
module rgb_window_decode
  import rgb_timer_pkg::*;
#(
  parameter int H_W  = 18,
  parameter int V_W  = 16,
  parameter int HS_W = 14,
  parameter int VS_W = 18
) (
  input  logic [H_W-1:0]  h_idx,
  input  logic [V_W-1:0]  v_idx,
  input  logic [HS_W-1:0] hs_width,
  input  logic [H_W-1:0]  h_wait,
  input  logic [H_W-1:0]  h_valid,
  input  logic [VS_W-1:0] vs_width,
  input  logic [V_W-1:0]  v_wait,
  input  logic [V_W-1:0]  v_active,
  output strobe_t         raw
);
  localparam int HC_W = ((H_W > HS_W) ? H_W : HS_W) + 1;
  localparam int VC_W = ((V_W > VS_W) ? V_W : VS_W) + 1;

  logic [HC_W-1:0] h_ext, hs_ext, hw_ext, h_end;
  logic [VC_W-1:0] v_ext, vs_ext, vw_ext, v_end;
  logic            h_in, v_in;

  always_comb begin
    h_ext  = HC_W'(h_idx);
    hs_ext = HC_W'(hs_width);
    hw_ext = HC_W'(h_wait);
    h_end  = HC_W'(h_wait) + HC_W'(h_valid);
    v_ext  = VC_W'(v_idx);
    vs_ext = VC_W'(vs_width);
    vw_ext = VC_W'(v_wait);
    v_end  = VC_W'(v_wait) + VC_W'(v_active);
    h_in   = (h_ext >= hw_ext) && (h_ext < h_end);
    v_in   = (v_ext >= vw_ext) && (v_ext < v_end);
    raw.hs = h_ext < hs_ext;
    raw.vs = v_ext < vs_ext;
    raw.de = h_in && v_in;
  end
endmodule

// File: rtl/rgb_out_stage.sv
// Two register stages: the first yields the pixel request, the second
// applies gating and polarity so the strobes trail the request by one clock.
module rgb_out_stage
  import rgb_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    run,
  input  strobe_t raw,
  input  logic    sync_en,
  input  logic    hs_pol,
  input  logic    vs_pol,
  input  logic    de_pol,
  output logic    hsync,
  output logic    vsync,
  output logic    de,
  output logic    pix_req
);
  strobe_t s1;

  always_ff @(posedge clk) begin
    if (rst)
      s1 <= '0;
    else
      s1 <= run ? raw : '0;
  end

  assign pix_req = s1.de;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= ~hs_pol;
      vsync <= ~vs_pol;
      de    <= ~de_pol;
    end else begin
      hsync <= (sync_en && s1.hs) ? hs_pol : ~hs_pol;
      vsync <= (sync_en && s1.vs) ? vs_pol : ~vs_pol;
      de    <= s1.de ? de_pol : ~de_pol;
    end
  end
endmodule

// File: rtl/rgb_buf_swap.sv
// Holds the pending frame address; promotes it at frame start.
module rgb_buf_swap #(
  parameter int A_W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [A_W-1:0] wr_addr,
  input  logic           swap,
  output logic [A_W-1:0] cur_buf,
  output logic           frame_start
);
  logic [A_W-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend        <= '0;
      cur_buf     <= '0;
      frame_start <= 1'b0;
    end else begin
      if (wr)
        pend <= wr_addr;
      if (swap)
        cur_buf <= pend;
      frame_start <= swap;
    end
  end
endmodule

// File: rtl/rgb_panel_timer.sv
module rgb_panel_timer
  import rgb_timer_pkg::*;
#(
  parameter int H_W  = 18,
  parameter int V_W  = 16,
  parameter int HS_W = 14,
  parameter int VS_W = 18,
  parameter int A_W  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [H_W-1:0]  cfg_h_total,
  input  logic [HS_W-1:0] cfg_hs_width,
  input  logic [H_W-1:0]  cfg_h_wait,
  input  logic [H_W-1:0]  cfg_h_valid,
  input  logic [V_W-1:0]  cfg_v_total,
  input  logic [VS_W-1:0] cfg_vs_width,
  input  logic [V_W-1:0]  cfg_v_wait,
  input  logic [V_W-1:0]  cfg_v_active,
  input  logic            cfg_hs_pol,
  input  logic            cfg_vs_pol,
  input  logic            cfg_de_pol,
  input  logic            cfg_clk_fall,
  input  logic            mode_en,
  input  logic            sync_en,
  input  logic            fifo_empty,
  input  logic            next_buf_wr,
  input  logic [A_W-1:0]  next_buf_addr,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic            pix_req,
  output logic            dclk_fall,
  output logic            run_status,
  output logic            frame_start,
  output logic [A_W-1:0]  cur_buf
);
  logic [H_W-1:0] h_idx;
  logic [V_W-1:0] v_idx;
  logic           h_wrap, v_wrap;
  logic           origin;
  strobe_t        raw;

  // Run control: start on request, stop only once the supply is drained.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_status <= 1'b0;
      dclk_fall  <= 1'b0;
    end else begin
      dclk_fall <= cfg_clk_fall;
      if (!run_status && mode_en)
        run_status <= 1'b1;
      else if (run_status && !mode_en && fifo_empty)
        run_status <= 1'b0;
    end
  end

  rgb_span_counter #(.W(H_W)) u_hcnt (
    .clk(clk), .rst(rst), .clr(!run_status), .step(run_status),
    .limit(cfg_h_total), .cnt(h_idx), .wrap(h_wrap)
  );

  rgb_span_counter #(.W(V_W)) u_vcnt (
    .clk(clk), .rst(rst), .clr(!run_status), .step(h_wrap),
    .limit(cfg_v_total), .cnt(v_idx), .wrap(v_wrap)
  );

  assign origin = run_status && (h_idx == '0) && (v_idx == '0);

  rgb_window_decode #(.H_W(H_W), .V_W(V_W), .HS_W(HS_W), .VS_W(VS_W)) u_dec (
    .h_idx(h_idx), .v_idx(v_idx), .hs_width(cfg_hs_width),
    .h_wait(cfg_h_wait), .h_valid(cfg_h_valid), .vs_width(cfg_vs_width),
    .v_wait(cfg_v_wait), .v_active(cfg_v_active), .raw(raw)
  );

  rgb_out_stage u_out (
    .clk(clk), .rst(rst), .run(run_status), .raw(raw), .sync_en(sync_en),
    .hs_pol(cfg_hs_pol), .vs_pol(cfg_vs_pol), .de_pol(cfg_de_pol),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req)
  );

  rgb_buf_swap #(.A_W(A_W)) u_swap (
    .clk(clk), .rst(rst), .wr(next_buf_wr), .wr_addr(next_buf_addr),
    .swap(origin), .cur_buf(cur_buf), .frame_start(frame_start)
  );

  logic unused_wrap;
  assign unused_wrap = v_wrap;
endmodule

// File: rtl/rgb_panel_timer_chk.sv
module rgb_panel_timer_chk #(
  parameter int A_W = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           hsync,
  input logic           vsync,
  input logic           de,
  input logic           pix_req,
  input logic           run_status,
  input logic           frame_start,
  input logic [A_W-1:0] cur_buf,
  input logic           cfg_hs_pol,
  input logic           cfg_vs_pol,
  input logic           cfg_de_pol,
  input logic           sync_en,
  input logic           mode_en,
  input logic           fifo_empty
);
  assert_req_leads_de_R5: assert property (@(posedge clk) disable iff (rst)
    pix_req |=> (de == $past(cfg_de_pol)));

  assert_sync_off_R7: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> (vsync == !$past(cfg_vs_pol)) && (hsync == !$past(cfg_hs_pol)));

  assert_buf_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !frame_start |-> $stable(cur_buf));

  assert_drain_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (run_status && !fifo_empty) |=> run_status);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!run_status && !$past(run_status)) |=> !pix_req);

  assert_start_R9: assert property (@(posedge clk) disable iff (rst)
    (!run_status && mode_en) |=> run_status);
endmodule

bind rgb_panel_timer rgb_panel_timer_chk #(.A_W(A_W)) u_chk (
  .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .de(de),
  .pix_req(pix_req), .run_status(run_status), .frame_start(frame_start),
  .cur_buf(cur_buf), .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
  .cfg_de_pol(cfg_de_pol), .sync_en(sync_en), .mode_en(mode_en),
  .fifo_empty(fifo_empty)
);

// File: tb/sim_rgb_panel_timer.sv
module sim_rgb_panel_timer;
  localparam int CLK_PERIOD = 10;
  localparam int HT = 10, HSW = 2, HWT = 4, HVL = 4;
  localparam int VT = 6, VSW = 1, VWT = 2, VAC = 3;
  localparam int FRAME = HT * VT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] cfg_h_total = 18'(HT);
  logic [13:0] cfg_hs_width = 14'(HSW);
  logic [17:0] cfg_h_wait = 18'(HWT);
  logic [17:0] cfg_h_valid = 18'(HVL);
  logic [15:0] cfg_v_total = 16'(VT);
  logic [17:0] cfg_vs_width = 18'(VSW);
  logic [15:0] cfg_v_wait = 16'(VWT);
  logic [15:0] cfg_v_active = 16'(VAC);
  logic        cfg_hs_pol = 1'b1, cfg_vs_pol = 1'b1, cfg_de_pol = 1'b1;
  logic        cfg_clk_fall = 1'b0;
  logic        mode_en = 1'b0, sync_en = 1'b1, fifo_empty = 1'b1;
  logic        next_buf_wr = 1'b0;
  logic [31:0] next_buf_addr = '0;
  logic        hsync, vsync, de, pix_req, dclk_fall, run_status, frame_start;
  logic [31:0] cur_buf;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgb_panel_timer u0 (
    .clk(clk), .rst(rst), .cfg_h_total(cfg_h_total), .cfg_hs_width(cfg_hs_width),
    .cfg_h_wait(cfg_h_wait), .cfg_h_valid(cfg_h_valid), .cfg_v_total(cfg_v_total),
    .cfg_vs_width(cfg_vs_width), .cfg_v_wait(cfg_v_wait), .cfg_v_active(cfg_v_active),
    .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol), .cfg_de_pol(cfg_de_pol),
    .cfg_clk_fall(cfg_clk_fall), .mode_en(mode_en), .sync_en(sync_en),
    .fifo_empty(fifo_empty), .next_buf_wr(next_buf_wr), .next_buf_addr(next_buf_addr),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req), .dclk_fall(dclk_fall),
    .run_status(run_status), .frame_start(frame_start), .cur_buf(cur_buf)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_hs(int pos); return (pos % HT) < HSW; endfunction
  function automatic bit m_vs(int pos); return ((pos / HT) % VT) < VSW; endfunction
  function automatic bit m_de(int pos);
    int h = pos % HT;
    int v = (pos / HT) % VT;
    return (h >= HWT) && (h < HWT + HVL) && (v >= VWT) && (v < VWT + VAC);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check("R1", "run_status", 32'(run_status), 0);
    check("R1", "cur_buf", cur_buf, 0);
    check("R1", "pix_req", 32'(pix_req), 0);
    check("R1", "hsync idle", 32'(hsync), 0);
    check("R1", "de idle", 32'(de), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "vsync after reset", 32'(vsync), 0);
  endtask

  // Starts a run and compares one full frame plus the next frame start.
  task automatic t_frame(input bit pol, input bit se, input logic [31:0] a0,
                         input logic [31:0] a1);
    int guard = 0;
    cfg_hs_pol = pol; cfg_vs_pol = pol; cfg_de_pol = pol; sync_en = se;
    next_buf_wr = 1'b1; next_buf_addr = a0;
    @(negedge clk);
    next_buf_wr = 1'b0;
    mode_en = 1'b1; fifo_empty = 1'b0;
    @(negedge clk);
    check("R9", "run_status rise", 32'(run_status), 1);
    while (!frame_start && guard < 10) begin @(negedge clk); guard++; end
    check("R9", "frame_start delay", 32'(guard), 1);
    for (int k = 0; k <= FRAME; k++) begin
      if (k == 0 || k == FRAME) begin
        check("R8", "frame_start pulse", 32'(frame_start), 1);
        check("R8", "cur_buf swap", cur_buf, (k == 0) ? a0 : a1);
      end else begin
        check("R8", "frame_start quiet", 32'(frame_start), 0);
      end
      if (k == FRAME - 1) check("R8", "cur_buf held", cur_buf, a0);
      if (k < FRAME) check("R5", "pix_req", 32'(pix_req), 32'(m_de(k)));
      if (k > 0) begin
        check(se ? "R2" : "R7", "hsync", 32'(hsync),
              32'(se ? (m_hs(k-1) ? pol : !pol) : !pol));
        check(se ? "R3" : "R7", "vsync", 32'(vsync),
              32'(se ? (m_vs(k-1) ? pol : !pol) : !pol));
        check("R4", "de", 32'(de), 32'(m_de(k-1) ? pol : !pol));
      end
      next_buf_wr = (k == 20);
      next_buf_addr = a1;
      @(negedge clk);
    end
    next_buf_wr = 1'b0;
  endtask

  task automatic t_stop(input bit pol);
    mode_en = 1'b0; fifo_empty = 1'b0;
    repeat (5) @(negedge clk);
    check("R10", "run held while draining", 32'(run_status), 1);
    fifo_empty = 1'b1;
    @(negedge clk);
    check("R10", "run cleared", 32'(run_status), 0);
    repeat (2) @(negedge clk);
    check("R10", "hsync idle", 32'(hsync), 32'(!pol));
    check("R10", "vsync idle", 32'(vsync), 32'(!pol));
    check("R10", "de idle", 32'(de), 32'(!pol));
    check("R10", "pix_req idle", 32'(pix_req), 0);
  endtask

  task automatic t_clk_edge();
    cfg_clk_fall = 1'b1;
    @(negedge clk);
    check("R11", "falling edge select", 32'(dclk_fall), 1);
    cfg_clk_fall = 1'b0;
    @(negedge clk);
    check("R11", "rising edge select", 32'(dclk_fall), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_frame(1'b1, 1'b1, 32'h1000_0000, 32'h2000_0000);   // R2 R3 R4 R6 active-high
    t_stop(1'b1);
    t_frame(1'b0, 1'b1, 32'h3000_0000, 32'h4000_0000);   // R6 active-low
    t_stop(1'b0);
    t_frame(1'b1, 1'b0, 32'h5000_0000, 32'h6000_0000);   // R7 sync disabled
    t_stop(1'b1);
    t_clk_edge();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule